// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block manages general-purpose pins in groups of 32 called banks, with up to three banks behind one register window. For each pin, software selects whether it drives or listens. It changes driven levels through two atomic registers, one that raises bits and one that lowers bits, so no read-modify-write is needed. Software reads back the synchronized pin level at any time.

Each input pin passes through a two-flop synchronizer. The controller compares the synchronized value with its previous sample and so sees rising and falling transitions. Each direction has its own per-pin enable. A qualifying transition sets a sticky status bit, and software clears it by writing a one. A per-pin mask chooses which status bits feed the single combined interrupt line.

The register port is a plain single-cycle interface. Writes commit on the clock edge where the write strobe is high. Read data is a combinational function of the address.

Top module: `banked_gpio_ctrl`

## Requirements
- R1: After reset, every register reads 0, pin_oe and pin_out are all 0, and irq is 0.
- R2: Bank n has its base at byte address ((n/3)<<8)+((n%3)<<2). The register groups sit at these offsets from the base: level 0x00, direction 0x0C, set 0x18, clear 0x24, rising enable 0x30, falling enable 0x3C, edge status 0x48, interrupt mask 0x9C. A read from any other address returns 0, and a write to any other address changes nothing.
- R3: A direction bit of 1 makes the pin an output, shown on pin_oe, and a direction bit of 0 makes it an input. A write to the direction register replaces it, and a read returns it.
- R4: Writing the set register raises each output latch bit written as 1 and leaves bits written as 0 unchanged. A read of either the set or the clear offset returns the output latch, which drives pin_out (bit p of bank b is pin b*32+p).
- R5: Writing the clear register lowers each output latch bit written as 1 and leaves bits written as 0 unchanged.
- R6: The level register returns pin_in after the two synchronizer stages, in either direction setting. Writes to the level register have no effect.
- R7: A 0-to-1 change of a synchronized pin sets its status bit only when its rising enable is 1. A 1-to-0 change sets its status bit only when its falling enable is 1. The status bit is set on the third rising clock edge after the pin changes.
- R8: A status bit stays set until a 1 is written to it. Writing 0 to a status bit leaves it unchanged.
- R9: If a new edge and a clearing write reach the same status bit in the same cycle, the bit ends set. Other bits cleared by the same write still clear.
- R10: irq is the OR, across all banks, of the status bits ANDed with the mask. The mask has no effect on the status bits themselves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 12 | Byte address of the register access |
| reg_we | input | 1 | Write strobe, committed on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pin_in | input | 96 | Raw pin inputs, bank-major |
| pin_out | output | 96 | Output latch values |
| pin_oe | output | 96 | Output enables (direction bits) |
| irq | output | 1 | Combined masked edge interrupt |

## Verification
A detected edge and a software write-one-to-clear can hit the same status register in the same cycle. The bench provokes this by changing a pin and then timing the clearing write so that it commits on exactly the edge where the synchronized transition is recorded. The clearing write covers both the pin that has the new edge and a pin whose status was already set. The check requires the new-edge bit to remain set and the older bit to clear, and the interrupt must stay high.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BANK_W  = 32;
    localparam int NUM_GRP = 8;

    typedef enum logic [2:0] {
        GRP_LEVEL = 3'd0,
        GRP_DIR   = 3'd1,
        GRP_SET   = 3'd2,
        GRP_CLR   = 3'd3,
        GRP_RISE  = 3'd4,
        GRP_FALL  = 3'd5,
        GRP_STAT  = 3'd6,
        GRP_MASK  = 3'd7
    } grp_e;

    typedef struct packed {
        logic [BANK_W-1:0] level;
        logic [BANK_W-1:0] dir;
        logic [BANK_W-1:0] drive;
        logic [BANK_W-1:0] rise_en;
        logic [BANK_W-1:0] fall_en;
        logic [BANK_W-1:0] status;
        logic [BANK_W-1:0] mask;
    } bank_view_t;

    function automatic int unsigned grp_offset(int unsigned g);
        case (g)
            0:       return 32'h00;
            1:       return 32'h0C;
            2:       return 32'h18;
            3:       return 32'h24;
            4:       return 32'h30;
            5:       return 32'h3C;
            6:       return 32'h48;
            default: return 32'h9C;
        endcase
    endfunction

    function automatic int unsigned bank_base(int unsigned n);
        return ((n / 3) << 8) + ((n % 3) << 2);
    endfunction

    function automatic logic [BANK_W-1:0] view_field(bank_view_t v, grp_e g);
        case (g)
            GRP_LEVEL: return v.level;
            GRP_DIR:   return v.dir;
            GRP_SET:   return v.drive;
            GRP_CLR:   return v.drive;
            GRP_RISE:  return v.rise_en;
            GRP_FALL:  return v.fall_en;
            GRP_STAT:  return v.status;
            default:   return v.mask;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int BANK_IDX = 0
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_GRP-1:0] hit
);
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam int unsigned ADDR_HIT = bank_base(BANK_IDX) + grp_offset(g);
        assign hit[g] = (addr == ADDR_W'(ADDR_HIT));
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_GRP-1:0] hit,
    input  logic               we,
    input  logic [BANK_W-1:0]  wdata,
    input  logic [BANK_W-1:0]  pin_raw,
    output logic [BANK_W-1:0]  pin_out,
    output logic [BANK_W-1:0]  pin_oe,
    output bank_view_t         view,
    output logic               irq_part
);
    logic [BANK_W-1:0] lvl, lvl_prev, ev;
    logic [BANK_W-1:0] dir_q, drv_q, ren_q, fen_q, st_q, msk_q;
    logic [BANK_W-1:0] set_bits, clr_bits, ack_bits;
    logic [NUM_GRP-1:0] wr;

    gpio_sync #(.W(BANK_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_raw),
        .q   (lvl)
    );

    assign wr       = hit & {NUM_GRP{we}};
    assign set_bits = wr[GRP_SET]  ? wdata : '0;
    assign clr_bits = wr[GRP_CLR]  ? wdata : '0;
    assign ack_bits = wr[GRP_STAT] ? wdata : '0;
    assign ev       = (lvl & ~lvl_prev & ren_q) | (~lvl & lvl_prev & fen_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_prev <= '0;
            dir_q    <= '0;
            drv_q    <= '0;
            ren_q    <= '0;
            fen_q    <= '0;
            st_q     <= '0;
            msk_q    <= '0;
        end else begin
            lvl_prev <= lvl;
            drv_q    <= (drv_q | set_bits) & ~clr_bits;
            st_q     <= (st_q & ~ack_bits) | ev;
            if (wr[GRP_DIR])  dir_q <= wdata;
            if (wr[GRP_RISE]) ren_q <= wdata;
            if (wr[GRP_FALL]) fen_q <= wdata;
            if (wr[GRP_MASK]) msk_q <= wdata;
        end
    end

    assign pin_out  = drv_q;
    assign pin_oe   = dir_q;
    assign irq_part = |(st_q & msk_q);

    always_comb begin
        view.level   = lvl;
        view.dir     = dir_q;
        view.drive   = drv_q;
        view.rise_en = ren_q;
        view.fall_en = fen_q;
        view.status  = st_q;
        view.mask    = msk_q;
    end

    // R8: without a status write, no set status bit drops
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        !wr[GRP_STAT] |=> ((st_q & $past(st_q)) == $past(st_q)));

    // R9: a detected edge always lands, even against a clearing write
    a_r9_edge_wins: assert property (@(posedge clk) disable iff (rst)
        (ev != '0) |=> ((st_q & $past(ev)) == $past(ev)));

    // R7: a status bit only rises because of an enabled edge
    a_r7_only_enabled: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((st_q & ~$past(st_q)) & ~$past(ev)) == '0));

    // R4: written-one bits of a set write are high afterwards
    a_r4_set_bits: assert property (@(posedge clk) disable iff (rst)
        wr[GRP_SET] |=> ((pin_out & $past(wdata)) == $past(wdata)));

    // R5: written-one bits of a clear write are low afterwards
    a_r5_clr_bits: assert property (@(posedge clk) disable iff (rst)
        wr[GRP_CLR] |=> ((pin_out & $past(wdata)) == '0));

    // R6: the level register ignores writes
    a_r6_level_ro: assert property (@(posedge clk) disable iff (rst)
        (wr[GRP_LEVEL] && !wr[GRP_DIR]) |=> $stable(dir_q));
endmodule

// File: rtl/banked_gpio_ctrl.sv
module banked_gpio_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_BANKS   = 3,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2,
    localparam int PINS       = NUM_BANKS * BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq
);
    logic [NUM_BANKS*NUM_GRP-1:0] all_hits;
    logic [BANK_W-1:0]            bank_rd  [NUM_BANKS];
    logic [NUM_BANKS-1:0]         bank_irq;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [NUM_GRP-1:0] hit;
        bank_view_t         view;

        gpio_addr_decode #(.ADDR_W(ADDR_W), .BANK_IDX(b)) u_dec (
            .addr (reg_addr),
            .hit  (hit)
        );

        gpio_bank #(.SYNC_STAGES(SYNC_STAGES)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .hit      (hit),
            .we       (reg_we),
            .wdata    (reg_wdata),
            .pin_raw  (pin_in[b*BANK_W +: BANK_W]),
            .pin_out  (pin_out[b*BANK_W +: BANK_W]),
            .pin_oe   (pin_oe[b*BANK_W +: BANK_W]),
            .view     (view),
            .irq_part (bank_irq[b])
        );

        assign all_hits[b*NUM_GRP +: NUM_GRP] = hit;

        always_comb begin
            bank_rd[b] = '0;
            for (int g = 0; g < NUM_GRP; g++)
                if (hit[g]) bank_rd[b] = bank_rd[b] | view_field(view, grp_e'(g));
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) reg_rdata = reg_rdata | bank_rd[b];
    end

    assign irq = |bank_irq;

    // R2: an address selects at most one register in the window
    a_r2_one_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0(all_hits));

    // R2: an unmapped address reads zero
    a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (all_hits == '0) |-> (reg_rdata == '0));
endmodule

// File: tb/banked_gpio_ctrl_bench.sv
`timescale 1ns/1ps
module banked_gpio_ctrl_bench;
    localparam int NB   = 3;
    localparam int PINS = NB * 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [11:0]     reg_addr = '0;
    logic            reg_we = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [PINS-1:0] pin_in = '0;
    logic [PINS-1:0] pin_out, pin_oe;
    logic            irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [31:0] m_dir [NB], m_out [NB], m_ren [NB], m_fen [NB], m_st [NB], m_msk [NB];

    always #2.5 clk = ~clk;

    banked_gpio_ctrl u_banked_gpio_ctrl (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [11:0] reg_at(int b, int g);
        int offs [8] = '{'h00, 'h0C, 'h18, 'h24, 'h30, 'h3C, 'h48, 'h9C};
        return 12'(((b / 3) << 8) + ((b % 3) << 2) + offs[g]);
    endfunction

    function automatic logic exp_irq();
        logic r = 1'b0;
        for (int b = 0; b < NB; b++) r |= |(m_st[b] & m_msk[b]);
        return r;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic model_write(int b, int g, logic [31:0] d);
        case (g)
            1: m_dir[b] = d;
            2: m_out[b] = m_out[b] | d;
            3: m_out[b] = m_out[b] & ~d;
            4: m_ren[b] = d;
            5: m_fen[b] = d;
            6: m_st[b]  = m_st[b] & ~d;
            7: m_msk[b] = d;
            default: ;
        endcase
    endtask

    task automatic change_pins(logic [PINS-1:0] nv);
        logic [PINS-1:0] old = pin_in;
        @(negedge clk);
        pin_in = nv;
        for (int b = 0; b < NB; b++) begin
            logic [31:0] o = old[b*32 +: 32];
            logic [31:0] n = nv[b*32 +: 32];
            m_st[b] = m_st[b] | (n & ~o & m_ren[b]) | (~n & o & m_fen[b]);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic verify_bank(int b);
        logic [31:0] v;
        rd(reg_at(b, 0), v); chk($sformatf("R6 level bank%0d", b), v, pin_in[b*32 +: 32]);
        rd(reg_at(b, 1), v); chk($sformatf("R3 dir bank%0d", b), v, m_dir[b]);
        rd(reg_at(b, 2), v); chk($sformatf("R4 set readback bank%0d", b), v, m_out[b]);
        rd(reg_at(b, 3), v); chk($sformatf("R5 clr readback bank%0d", b), v, m_out[b]);
        rd(reg_at(b, 4), v); chk($sformatf("R7 rise_en bank%0d", b), v, m_ren[b]);
        rd(reg_at(b, 5), v); chk($sformatf("R7 fall_en bank%0d", b), v, m_fen[b]);
        rd(reg_at(b, 6), v); chk($sformatf("R8 status bank%0d", b), v, m_st[b]);
        rd(reg_at(b, 7), v); chk($sformatf("R10 mask bank%0d", b), v, m_msk[b]);
        chk($sformatf("R3 pin_oe bank%0d", b), pin_oe[b*32 +: 32], m_dir[b]);
        chk($sformatf("R4 pin_out bank%0d", b), pin_out[b*32 +: 32], m_out[b]);
        chk("R10 irq", {31'b0, irq}, {31'b0, exp_irq()});
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        for (int b = 0; b < NB; b++) begin
            m_dir[b] = 0; m_out[b] = 0; m_ren[b] = 0; m_fen[b] = 0; m_st[b] = 0; m_msk[b] = 0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 irq", {31'b0, irq}, 32'd0);
        chk("R1 pin_oe", pin_oe[31:0] | pin_oe[63:32] | pin_oe[95:64], 32'd0);
        chk("R1 pin_out", pin_out[31:0] | pin_out[63:32] | pin_out[95:64], 32'd0);
        for (int b = 0; b < NB; b++) verify_bank(b);

        // R2: unmapped addresses read 0 and writes there change nothing
        wr(12'h100, 32'hFFFF_FFFF);
        wr(12'h0A8, 32'hFFFF_FFFF);
        wr(12'h01A, 32'hFFFF_FFFF);
        rd(12'h100, v); chk("R2 unmapped 0x100", v, 32'd0);
        rd(12'h0A8, v); chk("R2 unmapped 0x0A8", v, 32'd0);
        rd(12'h002, v); chk("R2 misaligned 0x002", v, 32'd0);
        for (int b = 0; b < NB; b++) verify_bank(b);

        // R4/R5: set and clear leave zero-written bits alone
        wr(reg_at(2, 2), 32'hF0F0_00FF); model_write(2, 2, 32'hF0F0_00FF);
        wr(reg_at(2, 3), 32'h0000_000F); model_write(2, 3, 32'h0000_000F);
        wr(reg_at(2, 2), 32'h0000_0000); model_write(2, 2, 32'h0000_0000);
        verify_bank(2);

        // R6: writes to level ignored; level follows pins regardless of direction
        wr(reg_at(0, 1), 32'hFFFF_0000); model_write(0, 1, 32'hFFFF_0000);
        wr(reg_at(0, 0), 32'hDEAD_BEEF);
        change_pins({32'h0, 32'h0, 32'h1234_8765});
        verify_bank(0);

        // R9: edge and clearing write in the same cycle on bank 1
        wr(reg_at(1, 4), 32'h0000_0060); model_write(1, 4, 32'h0000_0060);
        wr(reg_at(1, 7), 32'h0000_0060); model_write(1, 7, 32'h0000_0060);
        change_pins({32'h0, 32'h0000_0040, pin_in[31:0]});
        rd(reg_at(1, 6), v); chk("R7 bit6 captured", v, 32'h0000_0040);
        @(negedge clk);
        pin_in[32+5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_addr = reg_at(1, 6); reg_wdata = 32'h0000_0060; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        m_st[1] = 32'h0000_0020;
        rd(reg_at(1, 6), v); chk("R9 edge wins over clear", v, 32'h0000_0020);
        chk("R9 irq stays high", {31'b0, irq}, 32'd1);
        verify_bank(1);

        // R8/R10: clear remaining, irq drops
        wr(reg_at(1, 6), 32'hFFFF_FFFF); model_write(1, 6, 32'hFFFF_FFFF);
        chk("R10 irq low after clear", {31'b0, irq}, {31'b0, exp_irq()});

        // random mix
        for (int it = 0; it < 300; it++) begin
            int b = int'($urandom % NB);
            int op = int'($urandom % 9);
            logic [31:0] d = $urandom;
            if (op == 8) begin
                logic [PINS-1:0] np = pin_in;
                np[b*32 +: 32] = $urandom;
                change_pins(np);
            end else begin
                wr(reg_at(b, op), d);
                model_write(b, op, d);
            end
            if (it % 5 == 0) verify_bank(b);
            else chk("R10 irq random", {31'b0, irq}, {31'b0, exp_irq()});
        end
        for (int b = 0; b < NB; b++) verify_bank(b);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule